// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block is the programmable feedback divider of a frequency-synthesizer loop. It runs on the output clock of an external dual-modulus prescaler, so each of its clock cycles is one prescaler output pulse. From the programmed word N it derives a swallow count A and a main count B. It then drives the prescaler's modulus-control line so that the prescaler divides by P+1 for A of its cycles and by P for the remaining B−A cycles. The loop sees one divided pulse for every P·B+A cycles of the oscillator. That pulse goes to the phase detector.

One select bit picks the smaller or the larger prescaler modulus. The same parameterized RTL serves a wide high-band channel (18-bit word, P of 32 or 64) and a narrower low-band channel (15-bit word, P of 8 or 16). A powerdown bit halts the divider. A word that breaks the rule B ≥ A is flagged and clamped. A new word takes effect only at a period boundary.

Top module: `swallow_div`

## Requirements
- R1: While rst_n is low, and from the first cycle after pwrDown is sampled high until pwrDown is sampled low again, modCtl and divPulse are 0. wordErr is 0 while rst_n is low.
- R2: With bigMod = 0 the prescaler modulus is P = 2^PLOG (32 for the high-band default, 8 for low band), A is nWord[PLOG-1:0] and B is nWord[NWIDTH-1:PLOG]. With bigMod = 1, P = 2^(PLOG+1) (64 or 16), A is nWord[PLOG:0] and B is nWord[NWIDTH-1:PLOG+1].
- R3: Each divider period lasts B clock cycles. divPulse is 1 for exactly the last cycle of each period.
- R4: modCtl = 1 requests division by P+1. It is 1 for the first A cycles of a period and 0 for the rest. The oscillator total per period is therefore P·B+A.
- R5: If B < A, wordErr is 1 for every period that uses that word, and A is replaced by B. modCtl is then 1 for all B cycles.
- R6: nWord and bigMod are taken only on the clock edge that ends a period (the edge after the divPulse cycle). A change within a period leaves that period's length and swallow count unchanged.
- R7: A word with B = 0 gives a period of one cycle. divPulse is 1 every cycle and modCtl stays 0.
- R8: After reset release or powerdown release, the next cycle is the first cycle of a full period. That period uses the word present at the releasing edge.
- R9: The low-band configuration (NWIDTH = 15, PLOG = 3) obeys the same rules as the high-band default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nWord | input | NWIDTH | Programmed total division word N |
| bigMod | input | 1 | 0: smaller prescaler modulus, 1: larger |
| pwrDown | input | 1 | Halts the divider while high |
| modCtl | output | 1 | Modulus control to prescaler, 1 = divide by P+1 |
| divPulse | output | 1 | One-cycle pulse at the end of each period |
| wordErr | output | 1 | Active word had B < A and was clamped |

## Verification
The divided pulse and the swallow request fall in the same cycle when the swallow count equals the main count. This happens for an exact A = B word and for a clamped B < A word. The bench programs both kinds and judges the case by sampling modCtl in the cycle that carries divPulse. It also checks that the swallow-cycle count and the modelled oscillator total P·B+A (or (P+1)·B after a clamp) come out right. The second coincidence is a word change in the middle of a period, which coincides with the reload at the following boundary. The bench judges it by checking that the current period keeps the old length and swallow count and that the next period uses the new ones.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;
  typedef struct packed {
    logic load;     // take a new word and restart the count
    logic advance;  // step the period counter
  } divStrobe_t;
endpackage

// File: rtl/swallow_div_dp.sv
module swallow_div_dp
  import swallow_div_pkg::*;
#(
  parameter int NWIDTH = 18,
  parameter int PLOG   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  divStrobe_t        strobe,
  input  logic [NWIDTH-1:0] nWord,
  input  logic              bigMod,
  output logic              atEnd,
  output logic              inSwallow,
  output logic              wordErr
);
  localparam int AW = PLOG + 1;
  localparam int BW = NWIDTH - PLOG;

  logic [AW-1:0] aRaw, aNew, activeA;
  logic [BW-1:0] bNew, lastNew, lastCnt, cnt;
  logic          errNew, errQ;

  // split the word according to the prescaler size
  always_comb begin
    if (bigMod) begin
      aRaw = nWord[PLOG:0];
      bNew = BW'(nWord[NWIDTH-1:PLOG+1]);
    end else begin
      aRaw = AW'(nWord[PLOG-1:0]);
      bNew = nWord[NWIDTH-1:PLOG];
    end
    errNew  = BW'(aRaw) > bNew;
    aNew    = errNew ? AW'(bNew) : aRaw;
    lastNew = (bNew == '0) ? '0 : bNew - BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      lastCnt <= '0;
      activeA <= '0;
      errQ    <= 1'b0;
    end else if (strobe.load) begin
      cnt     <= '0;
      lastCnt <= lastNew;
      activeA <= aNew;
      errQ    <= errNew;
    end else if (strobe.advance) begin
      cnt <= cnt + BW'(1);
    end
  end

  assign atEnd     = (cnt == lastCnt);
  assign inSwallow = (cnt < BW'(activeA));
  assign wordErr   = errQ;
endmodule

// File: rtl/swallow_div_ctl.sv
module swallow_div_ctl
  import swallow_div_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrDown,
  input  logic       atEnd,
  input  logic       inSwallow,
  output divStrobe_t strobe,
  output logic       modCtl,
  output logic       divPulse
);
  logic stopped;

  // reset behaves like powerdown: reload every cycle, outputs quiet
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stopped <= 1'b1;
    else        stopped <= pwrDown;
  end

  always_comb begin
    strobe.load    = stopped | atEnd;
    strobe.advance = ~strobe.load;
    modCtl         = ~stopped & inSwallow;
    divPulse       = ~stopped & atEnd;
  end
endmodule

// File: rtl/swallow_div.sv
module swallow_div
  import swallow_div_pkg::*;
#(
  parameter int NWIDTH = 18,
  parameter int PLOG   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NWIDTH-1:0] nWord,
  input  logic              bigMod,
  input  logic              pwrDown,
  output logic              modCtl,
  output logic              divPulse,
  output logic              wordErr
);
  divStrobe_t strobe;
  logic       atEnd, inSwallow;

  swallow_div_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .pwrDown(pwrDown), .atEnd(atEnd),
    .inSwallow(inSwallow), .strobe(strobe), .modCtl(modCtl), .divPulse(divPulse)
  );

  swallow_div_dp #(.NWIDTH(NWIDTH), .PLOG(PLOG)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .nWord(nWord), .bigMod(bigMod),
    .atEnd(atEnd), .inSwallow(inSwallow), .wordErr(wordErr)
  );
endmodule

// File: rtl/swallow_div_chk.sv
module swallow_div_chk (
  input logic clk,
  input logic rst_n,
  input logic pwrDown,
  input logic modCtl,
  input logic divPulse,
  input logic wordErr
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_quiet_in_powerdown_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(pwrDown)) |-> (!modCtl && !divPulse));

  assert_swallow_ends_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !pwrDown && !$past(pwrDown) && !modCtl && !divPulse) |=> !modCtl);

  assert_clamp_swallows_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !pwrDown && wordErr && modCtl && !divPulse) |=> modCtl);

  assert_word_held_in_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !pwrDown && !$past(pwrDown) && !divPulse) |=> $stable(wordErr));
endmodule

bind swallow_div swallow_div_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwrDown(pwrDown),
  .modCtl(modCtl), .divPulse(divPulse), .wordErr(wordErr)
);

// File: tb/test_swallow_div.sv
module test_swallow_div;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [17:0] nWord = '0;
  logic bigMod = 1'b0, pwrDown = 1'b0;
  logic modCtl, divPulse, wordErr;
  logic [14:0] nWordLo = '0;
  logic bigModLo = 1'b0, pdLo = 1'b0;
  logic modLo, pulseLo, errLo;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  swallow_div i_swallow_div (
    .clk(clk), .rst_n(rst_n), .nWord(nWord), .bigMod(bigMod), .pwrDown(pwrDown),
    .modCtl(modCtl), .divPulse(divPulse), .wordErr(wordErr)
  );

  swallow_div #(.NWIDTH(15), .PLOG(3)) i_swallow_div_lo (
    .clk(clk), .rst_n(rst_n), .nWord(nWordLo), .bigMod(bigModLo), .pwrDown(pdLo),
    .modCtl(modLo), .divPulse(pulseLo), .wordErr(errLo)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitPulse(input bit lo);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(lo ? pulseLo : divPulse) && n < 3000);
  endtask

  // one period starting at the next cycle; prescaler model sums P or P+1
  task automatic measure(input bit lo, input int p, input int changeAt, input int newWord,
                         output int cyc, output int highs, output int vco,
                         output int errSeen, output int modAtPulse);
    logic m, pl;
    cyc = 0; highs = 0; vco = 0; errSeen = 0; modAtPulse = 0;
    do begin
      @(negedge clk);
      cyc++;
      m  = lo ? modLo : modCtl;
      pl = lo ? pulseLo : divPulse;
      if (m) highs++;
      vco += m ? p + 1 : p;
      errSeen = int'(lo ? errLo : wordErr);
      modAtPulse = int'(m);
      if (changeAt != 0 && cyc == changeAt) nWord = 18'(newWord);
    end while (!pl && cyc < 3000);
  endtask

  task automatic runCase(input string tag, input bit lo, input int w, input bit sel,
                         input int expB, input int expA, input int expN, input int expErr);
    int cyc, highs, vco, e, mp, p;
    if (lo) begin nWordLo = 15'(w); bigModLo = sel; p = sel ? 16 : 8; end
    else    begin nWord = 18'(w);   bigMod = sel;   p = sel ? 64 : 32; end
    waitPulse(lo);
    measure(lo, p, 0, 0, cyc, highs, vco, e, mp);
    check(cyc == expB,   {tag, " period length"}, cyc, expB);
    check(highs == expA, {tag, " swallow cycles"}, highs, expA);
    check(vco == expN,   {tag, " oscillator total"}, vco, expN);
    check(e == expErr,   {tag, " word error flag"}, e, expErr);
  endtask

  task automatic testReset();
    nWord = 18'd3207; nWordLo = 15'd489;
    repeat (3) @(negedge clk);
    check(!modCtl && !divPulse, "R1 outputs quiet in reset", int'(modCtl | divPulse), 0);
    check(!wordErr, "R1 wordErr clear in reset", int'(wordErr), 0);
    rst_n = 1'b1;
  endtask

  task automatic testCoincide();
    int cyc, highs, vco, e, mp;
    nWord = 18'd330; bigMod = 1'b0;   // A = B = 10
    waitPulse(0);
    measure(0, 32, 0, 0, cyc, highs, vco, e, mp);
    check(cyc == 10 && highs == 10, "R4 A equal B all swallow", highs, 10);
    check(mp == 1, "R4 modCtl with divPulse same cycle", mp, 1);
    check(vco == 330 && e == 0, "R4 A equal B total", vco, 330);
  endtask

  task automatic testZeroB();
    int cyc, highs, vco, e, mp;
    nWord = 18'd5; bigMod = 1'b0;     // B = 0, A = 5
    waitPulse(0);
    for (int i = 0; i < 3; i++) begin
      measure(0, 32, 0, 0, cyc, highs, vco, e, mp);
      check(cyc == 1, "R7 one-cycle period", cyc, 1);
      check(highs == 0, "R7 no swallow", highs, 0);
    end
    check(e == 1, "R7 flagged", e, 1);
  endtask

  task automatic testMidChange();
    int cyc, highs, vco, e, mp;
    nWord = 18'd3207; bigMod = 1'b0;
    waitPulse(0);
    measure(0, 32, 0, 0, cyc, highs, vco, e, mp);
    measure(0, 32, 20, 1603, cyc, highs, vco, e, mp);
    check(cyc == 100, "R6 current period kept", cyc, 100);
    check(highs == 7, "R6 current swallow kept", highs, 7);
    measure(0, 32, 0, 0, cyc, highs, vco, e, mp);
    check(cyc == 50 && highs == 3, "R6 next period uses new word", cyc, 50);
    check(vco == 1603, "R6 next total", vco, 1603);
  endtask

  task automatic testPowerdown();
    int cyc, highs, vco, e, mp, act;
    @(negedge clk);
    pwrDown = 1'b1;
    act = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (modCtl || divPulse) act++;
    end
    check(act == 0, "R1 quiet during powerdown", act, 0);
    nWord = 18'd1603; bigMod = 1'b0;
    pwrDown = 1'b0;
    measure(0, 32, 0, 0, cyc, highs, vco, e, mp);
    check(cyc == 50, "R8 full first period after wake", cyc, 50);
    check(highs == 3 && vco == 1603, "R8 first period total", vco, 1603);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    runCase("R2 R3 R4 small P", 0, 3207, 1'b0, 100, 7, 3207, 0);
    runCase("R2 large P", 0, 3885, 1'b1, 60, 45, 3885, 0);
    runCase("R2 same word small P", 0, 3885, 1'b0, 121, 13, 3885, 0);
    runCase("R5 clamp B below A", 0, 2605, 1'b1, 40, 40, 2600, 1);
    runCase("R5 recovery", 0, 2605, 1'b0, 81, 13, 2605, 0);
    testCoincide();
    testZeroB();
    testMidChange();
    testPowerdown();
    runCase("R9 low band large P", 1, 489, 1'b1, 30, 9, 489, 0);
    runCase("R9 low band small P", 1, 489, 1'b0, 61, 1, 489, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule